// File: doc/BRIEF.md
# Vector element index remapper

This block turns the linear element counter of a vector loop into a permuted element index. The permutation follows a three-dimensional loop nest. Software describes the nest in a shape register: three dimension sizes, an axis order and a small constant offset. A second register, the remap register, names the one register key whose accesses are permuted. Both registers are written through a simple CSR-style write port.

On every step of the loop the caller presents, for each operand, the element counter and that operand's register key. One cycle later the block returns an index for each operand. An operand whose key matches the remap entry gets the permuted index. Every other operand gets its counter unchanged. One operand can therefore be remapped while the other, in the same operation, walks linearly.

Internally the counter is reduced modulo the element count of the shape. It is then split into coordinates, with the innermost axis changing fastest. The coordinates are recombined into an X-major linear position, and the offset is added to it.

Top module: `elem_remap_top`

## Requirements
- R1: After reset, `idx_valid` is 0 and `idx_out` is 0. Both configuration registers read as zero, so every key is passed through: the index equals the counter.
- R2: A write with `cfg_addr` = 0x4F8 loads the shape register. Bits [6:0], [14:8] and [22:16] hold the X, Y and Z sizes minus one, so each size can be 1 to 128.
- R3: The shape word also carries a 3-bit offset. Offset bit 0 is word bit 7, offset bit 1 is word bit 15 and offset bit 2 is word bit 23. The offset is added to every remapped index.
- R4: Word bits [26:24] select the axis order, listed innermost first: 0=XYZ, 1=XZY, 2=YXZ, 3=YZX, 4=ZXY, 5=ZYX. The index is x + y*Xsize + z*Xsize*Ysize + offset. For sizes 3,2,1 with order 2, counters 0..5 give 0,3,1,4,2,5.
- R5: Order codes 6 and 7 behave exactly as code 0 (XYZ).
- R6: A write with `cfg_addr` = 0x4F7 loads the remap register. Bits [7:0] hold the selected key and bits [25:24] a shape selector. An operand is remapped only when its key equals the selected key, the key is nonzero and the selector is 0; otherwise its index is its counter. A remap register of all zeros disables remapping for every key, including key 0.
- R7: The operands are resolved independently in the same step. One can be remapped while another passes through.
- R8: A counter at or above Xsize*Ysize*Zsize wraps modulo that product before it is split into coordinates.
- R9: `idx_valid` is high exactly one cycle after a cycle with `step_valid` high. `idx_out` then holds the indices for that step.
- R10: A write to any other address changes neither register. A step presented in the same cycle as a configuration write uses the configuration in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration register address |
| cfg_wdata | input | 27 | Configuration write data |
| step_valid | input | 1 | A loop step is presented |
| step_cnt | input | 32 | Element counter per operand, 16 bits each, operand 0 in the low bits |
| step_key | input | 16 | Register key per operand, 8 bits each, operand 0 in the low bits |
| idx_valid | output | 1 | Indices of the previous step are valid |
| idx_out | output | 44 | Index per operand, 22 bits each, operand 0 in the low bits |

## Verification
A configuration write and a loop step can fall in the same cycle. The bench provokes this with a single drive that loads a new axis order while presenting a counter whose index differs between the old and the new order. It judges the result by expecting the index under the old configuration in that step, and under the new one in the following step. A second overlap is one operand hitting the remap entry while the other misses it in the same step. The bench judges this by checking both lanes against its own loop-walking model.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int DIMW     = 7;
  localparam int KEYW     = 8;
  localparam int SELW     = 2;
  localparam int PERMW    = 3;
  localparam int OFFW     = 3;
  localparam int X_LSB    = 0;
  localparam int Y_LSB    = 8;
  localparam int Z_LSB    = 16;
  localparam int PERM_LSB = 24;
  localparam int SEL_LSB  = 24;
  localparam int CSR_W    = PERM_LSB + PERMW;
  localparam int PRODW    = 3 * DIMW + 1;

  typedef struct packed {
    logic [DIMW:0]      xs;
    logic [DIMW:0]      ys;
    logic [DIMW:0]      zs;
    logic [PERMW-1:0]   perm;
    logic [OFFW-1:0]    offs;
  } shape_t;

  typedef struct packed {
    logic [KEYW-1:0] key;
    logic [SELW-1:0] sel;
  } remap_t;

  // axis codes (0=x,1=y,2=z), innermost first; reserved codes fall back to XYZ
  function automatic logic [5:0] perm_axes(input logic [PERMW-1:0] p);
    case (p)
      3'd1:    return {2'd1, 2'd2, 2'd0};
      3'd2:    return {2'd2, 2'd0, 2'd1};
      3'd3:    return {2'd0, 2'd2, 2'd1};
      3'd4:    return {2'd1, 2'd0, 2'd2};
      3'd5:    return {2'd0, 2'd1, 2'd2};
      default: return {2'd2, 2'd1, 2'd0};
    endcase
  endfunction

  // counter -> X-major position under the permuted nest
  function automatic int unsigned nest_pos(input int unsigned cnt,
                                           input int unsigned xs,
                                           input int unsigned ys,
                                           input int unsigned zs,
                                           input int unsigned prod,
                                           input logic [PERMW-1:0] p);
    int unsigned sz [3];
    int unsigned co [3];
    int unsigned c, t;
    logic [5:0] ax;
    sz[0] = xs; sz[1] = ys; sz[2] = zs;
    ax = perm_axes(p);
    c = cnt % prod;
    co[ax[1:0]] = c % sz[ax[1:0]];
    t = c / sz[ax[1:0]];
    co[ax[3:2]] = t % sz[ax[3:2]];
    co[ax[5:4]] = t / sz[ax[3:2]];
    return co[0] + co[1] * xs + co[2] * xs * ys;
  endfunction
endpackage

// File: rtl/remap_cfg.sv
module remap_cfg
  import remap_pkg::*;
#(
  parameter logic [11:0] SHAPE_ADDR = 12'h4F8,
  parameter logic [11:0] REMAP_ADDR = 12'h4F7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [11:0]       cfg_addr,
  input  logic [CSR_W-1:0]  cfg_wdata,
  output shape_t            shp,
  output remap_t            rmp,
  output logic [PRODW-1:0]  prod
);
  shape_t shp_q;
  remap_t rmp_q;
  logic   wr_shape, wr_remap;

  assign wr_shape = cfg_we && (cfg_addr == SHAPE_ADDR);
  assign wr_remap = cfg_we && (cfg_addr == REMAP_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shp_q <= '0;
      rmp_q <= '0;
    end else begin
      if (wr_shape) begin
        shp_q.xs   <= {1'b0, cfg_wdata[X_LSB +: DIMW]};
        shp_q.ys   <= {1'b0, cfg_wdata[Y_LSB +: DIMW]};
        shp_q.zs   <= {1'b0, cfg_wdata[Z_LSB +: DIMW]};
        shp_q.perm <= cfg_wdata[PERM_LSB +: PERMW];
        shp_q.offs <= {cfg_wdata[Z_LSB+DIMW], cfg_wdata[Y_LSB+DIMW], cfg_wdata[X_LSB+DIMW]};
      end
      if (wr_remap) begin
        rmp_q.key <= cfg_wdata[KEYW-1:0];
        rmp_q.sel <= cfg_wdata[SEL_LSB +: SELW];
      end
    end
  end

  // stored fields are size-1; present true sizes
  always_comb begin
    shp      = shp_q;
    shp.xs   = shp_q.xs + 1'b1;
    shp.ys   = shp_q.ys + 1'b1;
    shp.zs   = shp_q.zs + 1'b1;
  end
  assign rmp  = rmp_q;
  assign prod = PRODW'(shp.xs) * PRODW'(shp.ys) * PRODW'(shp.zs);

  // R10: only a write to one of the two addresses changes state
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || (cfg_addr != SHAPE_ADDR && cfg_addr != REMAP_ADDR))
      |=> ($stable(shp_q) && $stable(rmp_q)));
endmodule

// File: rtl/remap_calc.sv
module remap_calc
  import remap_pkg::*;
#(
  parameter int CW = 16,
  parameter int IW = 22
) (
  input  shape_t            shp,
  input  remap_t            rmp,
  input  logic [PRODW-1:0]  prod,
  input  logic [CW-1:0]     cnt,
  input  logic [KEYW-1:0]   key,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  int unsigned pos;

  assign hit = (key == rmp.key) && (rmp.key != '0) && (rmp.sel == '0);

  always_comb begin
    pos = nest_pos(int'(cnt), int'(shp.xs), int'(shp.ys), int'(shp.zs),
                   int'(prod), shp.perm);
    if (hit) idx = IW'(pos + int'(shp.offs));
    else     idx = IW'(cnt);
  end
endmodule

// File: rtl/elem_remap_top.sv
module elem_remap_top
  import remap_pkg::*;
#(
  parameter int          NOPS       = 2,
  parameter int          CW         = 16,
  parameter logic [11:0] SHAPE_ADDR = 12'h4F8,
  parameter logic [11:0] REMAP_ADDR = 12'h4F7,
  localparam int         IW         = (PRODW > CW) ? PRODW : CW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [11:0]          cfg_addr,
  input  logic [CSR_W-1:0]     cfg_wdata,
  input  logic                 step_valid,
  input  logic [NOPS*CW-1:0]   step_cnt,
  input  logic [NOPS*KEYW-1:0] step_key,
  output logic                 idx_valid,
  output logic [NOPS*IW-1:0]   idx_out
);
  shape_t           shp;
  remap_t           rmp;
  logic [PRODW-1:0] prod;
  logic [NOPS-1:0]  hit_w;
  logic [NOPS*IW-1:0] idx_w;

  remap_cfg #(.SHAPE_ADDR(SHAPE_ADDR), .REMAP_ADDR(REMAP_ADDR)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .shp, .rmp, .prod
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    remap_calc #(.CW(CW), .IW(IW)) u_calc (
      .shp, .rmp, .prod,
      .cnt (step_cnt[g*CW +: CW]),
      .key (step_key[g*KEYW +: KEYW]),
      .hit (hit_w[g]),
      .idx (idx_w[g*IW +: IW])
    );

    // R6: a missed key returns the counter one cycle later
    a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && !hit_w[g]) |=>
        (idx_out[g*IW +: IW] == IW'($past(step_cnt[g*CW +: CW]))));

    // R8: a remapped index stays inside the shape plus offset
    a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && hit_w[g]) |=>
        (int'(idx_out[g*IW +: IW]) < int'($past(prod)) + int'($past(shp.offs))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_valid <= 1'b0;
      idx_out   <= '0;
    end else begin
      idx_valid <= step_valid;
      if (step_valid) idx_out <= idx_w;
    end
  end

  // R9: valid follows the step by exactly one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |=> idx_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> !idx_valid);
endmodule

// File: tb/sim_elem_remap_top.sv
`timescale 1ns/1ps
module sim_elem_remap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [26:0] cfg_wdata = '0;
  logic        step_valid = 1'b0;
  logic [31:0] step_cnt = '0;
  logic [15:0] step_key = '0;
  logic        idx_valid;
  logic [43:0] idx_out;

  int checks = 0;
  int errors = 0;

  int    q0 [$];
  int    q1 [$];
  string qt [$];

  // model state
  int m_xs = 1, m_ys = 1, m_zs = 1, m_perm = 0, m_off = 0, m_key = 0, m_sel = 0;

  always #2.5 clk = ~clk;

  elem_remap_top u0 (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .step_valid, .step_cnt, .step_key, .idx_valid, .idx_out
  );

  function automatic int mk_shape(int x, int y, int z, int off, int perm);
    return (x-1) | ((y-1) << 8) | ((z-1) << 16) | (perm << 24) |
           ((off & 1) << 7) | (((off >> 1) & 1) << 15) | (((off >> 2) & 1) << 23);
  endfunction

  function automatic int mk_remap(int key, int sel);
    return key | (sel << 24);
  endfunction

  function automatic void model_write(int addr, int d);
    if (addr == 'h4F8) begin
      m_xs = (d & 'h7F) + 1;
      m_ys = ((d >> 8) & 'h7F) + 1;
      m_zs = ((d >> 16) & 'h7F) + 1;
      m_perm = (d >> 24) & 7;
      m_off = ((d >> 7) & 1) | (((d >> 15) & 1) << 1) | (((d >> 23) & 1) << 2);
    end else if (addr == 'h4F7) begin
      m_key = d & 'hFF;
      m_sel = (d >> 24) & 3;
    end
  endfunction

  // walks the loop nest one element at a time
  function automatic int exp_idx(int c, int key);
    int s [3];
    int a [3];
    int o [3];
    int n;
    if (!(key == m_key && m_key != 0 && m_sel == 0)) return c;
    s[0] = m_xs; s[1] = m_ys; s[2] = m_zs;
    case (m_perm)
      1: begin o[0] = 0; o[1] = 2; o[2] = 1; end
      2: begin o[0] = 1; o[1] = 0; o[2] = 2; end
      3: begin o[0] = 1; o[1] = 2; o[2] = 0; end
      4: begin o[0] = 2; o[1] = 0; o[2] = 1; end
      5: begin o[0] = 2; o[1] = 1; o[2] = 0; end
      default: begin o[0] = 0; o[1] = 1; o[2] = 2; end
    endcase
    a[0] = 0; a[1] = 0; a[2] = 0;
    n = c % (m_xs * m_ys * m_zs);
    for (int i = 0; i < n; i++) begin
      a[o[0]]++;
      if (a[o[0]] == s[o[0]]) begin
        a[o[0]] = 0; a[o[1]]++;
        if (a[o[1]] == s[o[1]]) begin
          a[o[1]] = 0; a[o[2]]++;
          if (a[o[2]] == s[o[2]]) a[o[2]] = 0;
        end
      end
    end
    return a[0] + a[1] * m_xs + a[2] * m_xs * m_ys + m_off;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(int c0, int k0, int c1, int k1, string tag);
    q0.push_back(exp_idx(c0, k0));
    q1.push_back(exp_idx(c1, k1));
    qt.push_back(tag);
  endtask

  task automatic drive_step(int c0, int k0, int c1, int k1, string tag);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    step_valid = 1'b1;
    step_cnt = {16'(c1), 16'(c0)};
    step_key = {8'(k1), 8'(k0)};
    push(c0, k0, c1, k1, tag);
  endtask

  task automatic drive_cfg(int addr, int d);
    @(posedge clk); #1;
    step_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_addr = 12'(addr);
    cfg_wdata = 27'(d);
    model_write(addr, d);
  endtask

  task automatic drive_both(int addr, int d, int c0, int k0, int c1, int k1, string tag);
    @(posedge clk); #1;
    cfg_we = 1'b1;
    cfg_addr = 12'(addr);
    cfg_wdata = 27'(d);
    step_valid = 1'b1;
    step_cnt = {16'(c1), 16'(c0)};
    step_key = {8'(k1), 8'(k0)};
    push(c0, k0, c1, k1, tag);
    model_write(addr, d);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    cfg_we = 1'b0;
    step_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && idx_valid) begin
      if (q0.size() == 0) begin
        check("R9 unexpected valid", 1, 0);
      end else begin
        string t;
        t = qt.pop_front();
        check({t, " op0"}, int'(idx_out[21:0]), q0.pop_front());
        check({t, " op1"}, int'(idx_out[43:22]), q1.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    check("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", int'(idx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(idx_valid), 0);
    check("R1 idx after reset", int'(idx_out), 0);

    // R1: reset state passes everything through
    drive_step(7, 0, 3, 9, "R1");
    drive_step(40000, 1, 12, 0, "R1");
    idle();

    // R4 / R7: sizes 3,2,1, order YXZ, key 1 selected
    drive_cfg('h4F8, mk_shape(3, 2, 1, 0, 2));
    drive_cfg('h4F7, mk_remap(1, 0));
    for (int c = 0; c < 6; c++) drive_step(c, 1, c, 7, "R4 R7");
    for (int c = 0; c < 6; c++) drive_step(c, 7, 5 - c, 1, "R7");
    // R9: single-cycle step surrounded by idle cycles
    idle();
    drive_step(2, 1, 2, 1, "R9");
    idle();
    idle();
    // R8: counters past the element count wrap
    for (int c = 6; c < 14; c++) drive_step(c, 1, c + 100, 1, "R8");

    // R3: offset 5 spread over bits 7 and 23
    drive_cfg('h4F8, mk_shape(3, 2, 1, 5, 2));
    for (int c = 0; c < 6; c++) drive_step(c, 1, c, 2, "R3");
    drive_cfg('h4F8, mk_shape(3, 2, 1, 2, 0));
    drive_step(4, 1, 4, 1, "R3");

    // R2 / R4 / R5: sizes 5,4,3 under every order code, with wrap
    for (int p = 0; p < 8; p++) begin
      drive_cfg('h4F8, mk_shape(5, 4, 3, 0, p));
      for (int c = 0; c < 70; c += 3) drive_step(c, 1, c + 1, 1, (p > 5) ? "R5" : "R2 R4");
    end
    // R2: largest X field
    drive_cfg('h4F8, mk_shape(128, 2, 1, 0, 0));
    drive_step(200, 1, 300, 1, "R2");
    drive_cfg('h4F8, mk_shape(128, 2, 1, 0, 2));
    drive_step(3, 1, 255, 1, "R2");
    drive_cfg('h4F8, mk_shape(2, 3, 128, 7, 4));
    drive_step(517, 1, 9, 1, "R2");

    // R6: nonzero selector disables, zero register disables key 0
    drive_cfg('h4F7, mk_remap(1, 1));
    drive_step(3, 1, 4, 1, "R6");
    drive_cfg('h4F7, mk_remap(0, 0));
    drive_step(3, 0, 5, 1, "R6");
    drive_cfg('h4F7, mk_remap(9, 0));
    drive_step(3, 9, 3, 1, "R6");

    // R10: write to an unrelated address is ignored
    drive_cfg('h4F8, mk_shape(3, 2, 1, 0, 2));
    drive_cfg('h4F6, mk_shape(5, 5, 5, 7, 5));
    drive_cfg('h4F9, mk_remap(0, 0));
    drive_step(1, 9, 2, 9, "R10");
    // R10: write and step in the same cycle use the old configuration
    drive_both('h4F8, mk_shape(3, 2, 1, 0, 0), 1, 9, 2, 9, "R10");
    drive_step(1, 9, 2, 9, "R10");
    drive_both('h4F7, mk_remap(0, 0), 4, 9, 4, 3, "R10");
    drive_step(4, 9, 4, 3, "R10");
    idle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9 queue drained", q0.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule